// File: doc/BRIEF.md
# Page Storage-Key Reference and Change Updater

This block keeps the usage bits of per-page storage keys current. After an address translation succeeds, the translation logic hands it the absolute address of the access, the kind of access (load, store or instruction fetch) and the permission flags it is about to install. The block turns the address into a page index and reads that page's key from an external key RAM. It then forms the new key: the reference bit is always set, and the change bit is also set when the access is a store. The key is written back only when this new value differs from the old one. The adjusted permission flags are returned with a one-cycle done pulse.

The permission adjustment keeps change tracking exact when the resulting mapping is cached. A load or fetch that finds the change bit clear hands back the flags with write permission removed. A later store to the same page therefore misses again and comes back through this block, which then records the change. A global enable, sampled when a request is accepted, bypasses all key activity: the flags come back untouched after one cycle and the key RAM is never accessed. A read error reported by the key RAM cancels the update and returns the flags unchanged.

Top module: `pgkey_rc_engine`

## Requirements
- R1: After reset `done`, `kr_rd_en` and `kr_wr_en` are low and `req_ready` is high.
- R2: When `keys_on` is low at acceptance, `done` rises in the cycle after acceptance. `perm_out` then equals `req_perm`, and neither `kr_rd_en` nor `kr_wr_en` is raised.
- R3: When enabled, `kr_rd_en` is high for exactly the one cycle after acceptance. During that cycle `kr_addr` carries the page index `req_addr >> PAGE_SHIFT` (bits 15:12 by default). Any write-back goes to the same index.
- R4: Every enabled access without a read error leaves bit 2 (reference) of the stored key set, whatever the access kind.
- R5: A store (`req_kind` = 1) also sets bit 1 (change). Loads (`req_kind` = 0, and 3, which is treated as a load) and fetches (`req_kind` = 2) leave bit 1 as it was. Bits 6:3 (access-control key) and bit 0 are never modified.
- R6: For a load or fetch that reads a key whose bit 1 is clear, `perm_out` is `req_perm` with bit 1 (write permission) cleared. In every other enabled, error-free case `perm_out` equals `req_perm`. Bit 0 of the flags is read permission and bit 2 is execute permission.
- R7: The key is written back (`kr_wr_en`, one cycle) only when the new key differs from the one read, so there is at most one write per request.
- R8: If `kr_rd_err` is high with the read data, nothing is written and `perm_out` equals `req_perm`.
- R9: When enabled, `done` is a single-cycle pulse three cycles after acceptance. `req_ready` is low from acceptance until `done` has fallen.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keys_on | input | 1 | Global enable for key handling, sampled at acceptance |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Engine idle and able to accept |
| req_addr | input | ADDR_W | Absolute address of the access |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_perm | input | PERM_W | Permission flags from translation (bit 0 read, 1 write, 2 execute) |
| done | output | 1 | One-cycle completion pulse |
| perm_out | output | PERM_W | Adjusted permission flags, valid while `done` is high |
| kr_rd_en | output | 1 | Key RAM read strobe |
| kr_wr_en | output | 1 | Key RAM write strobe |
| kr_addr | output | ADDR_W-PAGE_SHIFT | Key RAM page index for read and write |
| kr_rd_data | input | KEY_W | Key read, valid in the cycle after `kr_rd_en` |
| kr_rd_err | input | 1 | Read error, valid with `kr_rd_data` |
| kr_wr_data | output | KEY_W | Key to write |

## Verification
The assertions assume the key RAM has exactly one cycle of read latency. They also assume that `kr_rd_data` and `kr_rd_err` hold steady through the cycle after a read strobe, because the write-back properties compare the written key with the data being read. The bench's key RAM model registers data and error on the read strobe and changes them on no other edge. Requests are driven only while the engine is idle, and `keys_on` is held for the whole of an operation. Expected keys, write counts and flags come from simple bit arithmetic applied to every 7-bit starting key under each access kind.

// File: rtl/pgkey_pkg.sv
package pgkey_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_EVAL = 2'd2,
      ST_DONE = 2'd3
   } eng_state_e;

endpackage

// File: rtl/pgkey_index.sv
module pgkey_index #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [ADDR_W-1:0]            addr,
   output logic [ADDR_W-PAGE_SHIFT-1:0] page
);

   generate
      if (PAGE_SHIFT == 0) begin : g_flat
         assign page = addr;
      end else begin : g_paged
         logic unused_offset;
         assign page          = addr[ADDR_W-1:PAGE_SHIFT];
         assign unused_offset = ^addr[PAGE_SHIFT-1:0];
      end
   endgenerate

endmodule

// File: rtl/pgkey_merge.sv
module pgkey_merge #(
   parameter int KEY_W       = 7,
   parameter int REF_BIT     = 2,
   parameter int CHG_BIT     = 1,
   parameter int PERM_W      = 3,
   parameter int WR_PERM_BIT = 1
) (
   input  logic [KEY_W-1:0]  old_key,
   input  logic              is_store,
   input  logic [PERM_W-1:0] perm_in,
   output logic [KEY_W-1:0]  new_key,
   output logic [PERM_W-1:0] perm_adj,
   output logic              changed
);

   generate
      for (genvar i = 0; i < KEY_W; i++) begin : g_key
         if (i == REF_BIT) begin : g_ref
            assign new_key[i] = 1'b1;
         end else if (i == CHG_BIT) begin : g_chg
            assign new_key[i] = old_key[i] | is_store;
         end else begin : g_keep
            assign new_key[i] = old_key[i];
         end
      end

      for (genvar j = 0; j < PERM_W; j++) begin : g_perm
         if (j == WR_PERM_BIT) begin : g_wr
            // Write stays granted only if this is a store or the page is already dirty.
            assign perm_adj[j] = perm_in[j] & (is_store | old_key[CHG_BIT]);
         end else begin : g_pass
            assign perm_adj[j] = perm_in[j];
         end
      end
   endgenerate

   assign changed = (new_key != old_key);

endmodule

// File: rtl/pgkey_ctrl.sv
module pgkey_ctrl
   import pgkey_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int PERM_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              keys_on,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_page,
   input  logic              req_store,
   input  logic [PERM_W-1:0] req_perm,
   input  logic              rd_err,
   input  logic              changed,
   input  logic [PERM_W-1:0] perm_adj,
   output logic              req_ready,
   output logic              rd_en,
   output logic              wr_en,
   output logic [IDX_W-1:0]  page_q,
   output logic              store_q,
   output logic [PERM_W-1:0] perm_q,
   output logic              done,
   output logic [PERM_W-1:0] perm_out
);

   eng_state_e        state;
   logic [PERM_W-1:0] perm_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         page_q   <= '0;
         store_q  <= 1'b0;
         perm_q   <= '0;
         perm_res <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  page_q  <= req_page;
                  store_q <= req_store;
                  perm_q  <= req_perm;
                  if (keys_on) begin
                     state <= ST_RD;
                  end else begin
                     perm_res <= req_perm;
                     state    <= ST_DONE;
                  end
               end
            end
            ST_RD: state <= ST_EVAL;
            ST_EVAL: begin
               perm_res <= rd_err ? perm_q : perm_adj;
               state    <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rd_en     = (state == ST_RD);
   assign wr_en     = (state == ST_EVAL) && !rd_err && changed;
   assign done      = (state == ST_DONE);
   assign perm_out  = perm_res;

endmodule

// File: rtl/pgkey_rc_engine.sv
module pgkey_rc_engine
   import pgkey_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int PAGE_SHIFT  = 12,
   parameter int KEY_W       = 7,
   parameter int REF_BIT     = 2,
   parameter int CHG_BIT     = 1,
   parameter int PERM_W      = 3,
   parameter int WR_PERM_BIT = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         keys_on,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [1:0]                   req_kind,
   input  logic [PERM_W-1:0]            req_perm,
   output logic                         done,
   output logic [PERM_W-1:0]            perm_out,
   output logic                         kr_rd_en,
   output logic                         kr_wr_en,
   output logic [ADDR_W-PAGE_SHIFT-1:0] kr_addr,
   input  logic [KEY_W-1:0]             kr_rd_data,
   input  logic                         kr_rd_err,
   output logic [KEY_W-1:0]             kr_wr_data
);

   localparam int IDX_W = ADDR_W - PAGE_SHIFT;

   generate
      if (PAGE_SHIFT < 0 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("PAGE_SHIFT must lie in [0, ADDR_W)");
      end
      if (REF_BIT >= KEY_W || CHG_BIT >= KEY_W || REF_BIT == CHG_BIT) begin : g_bad_key
         $error("REF_BIT and CHG_BIT must be distinct bits of the key");
      end
      if (WR_PERM_BIT >= PERM_W) begin : g_bad_perm
         $error("WR_PERM_BIT must lie inside the permission field");
      end
   endgenerate

   logic [IDX_W-1:0]  req_page;
   logic              store_q;
   logic [PERM_W-1:0] perm_q;
   logic [PERM_W-1:0] perm_adj;
   logic              changed;

   pgkey_index #(
      .ADDR_W    (ADDR_W),
      .PAGE_SHIFT(PAGE_SHIFT)
   ) u_index (
      .addr(req_addr),
      .page(req_page)
   );

   pgkey_ctrl #(
      .IDX_W (IDX_W),
      .PERM_W(PERM_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .keys_on  (keys_on),
      .req_valid(req_valid),
      .req_page (req_page),
      .req_store(req_kind == ACC_STORE),
      .req_perm (req_perm),
      .rd_err   (kr_rd_err),
      .changed  (changed),
      .perm_adj (perm_adj),
      .req_ready(req_ready),
      .rd_en    (kr_rd_en),
      .wr_en    (kr_wr_en),
      .page_q   (kr_addr),
      .store_q  (store_q),
      .perm_q   (perm_q),
      .done     (done),
      .perm_out (perm_out)
   );

   pgkey_merge #(
      .KEY_W      (KEY_W),
      .REF_BIT    (REF_BIT),
      .CHG_BIT    (CHG_BIT),
      .PERM_W     (PERM_W),
      .WR_PERM_BIT(WR_PERM_BIT)
   ) u_merge (
      .old_key (kr_rd_data),
      .is_store(store_q),
      .perm_in (perm_q),
      .new_key (kr_wr_data),
      .perm_adj(perm_adj),
      .changed (changed)
   );

endmodule

// File: rtl/pgkey_rc_chk.sv
module pgkey_rc_chk #(
   parameter int KEY_W   = 7,
   parameter int IDX_W   = 4,
   parameter int REF_BIT = 2,
   parameter int CHG_BIT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             keys_on,
   input logic             req_valid,
   input logic             req_ready,
   input logic             done,
   input logic             kr_rd_en,
   input logic             kr_wr_en,
   input logic [IDX_W-1:0] kr_addr,
   input logic [KEY_W-1:0] kr_rd_data,
   input logic             kr_rd_err,
   input logic [KEY_W-1:0] kr_wr_data
);

   localparam logic [KEY_W-1:0] MOD_MASK = KEY_W'((1 << REF_BIT) | (1 << CHG_BIT));

   a_r2_off_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !keys_on) |=> (done && !kr_rd_en && !kr_wr_en));

   a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      kr_rd_en |=> !kr_rd_en);

   a_r3_write_same_page: assert property (@(posedge clk) disable iff (!rst_n)
      kr_wr_en |-> ($past(kr_rd_en) && kr_addr == $past(kr_addr)));

   a_r4_ref_written: assert property (@(posedge clk) disable iff (!rst_n)
      kr_wr_en |-> kr_wr_data[REF_BIT]);

   a_r5_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      kr_wr_en |-> ((kr_wr_data & ~MOD_MASK) == (kr_rd_data & ~MOD_MASK)));

   a_r7_write_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      kr_wr_en |-> (kr_wr_data != kr_rd_data));

   a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      kr_wr_en |=> !kr_wr_en);

   a_r8_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      kr_wr_en |-> !kr_rd_err);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && keys_on) |=> (!req_ready && kr_rd_en));

endmodule

bind pgkey_rc_engine pgkey_rc_chk #(
   .KEY_W  (KEY_W),
   .IDX_W  (ADDR_W - PAGE_SHIFT),
   .REF_BIT(REF_BIT),
   .CHG_BIT(CHG_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .keys_on   (keys_on),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .kr_rd_en  (kr_rd_en),
   .kr_wr_en  (kr_wr_en),
   .kr_addr   (kr_addr),
   .kr_rd_data(kr_rd_data),
   .kr_rd_err (kr_rd_err),
   .kr_wr_data(kr_wr_data)
);

// File: tb/tb_pgkey_rc_engine.sv
`timescale 1ns/1ps
module tb_pgkey_rc_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        keys_on = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic [2:0]  req_perm = '0;
   logic        done;
   logic [2:0]  perm_out;
   logic        kr_rd_en;
   logic        kr_wr_en;
   logic [3:0]  kr_addr;
   logic [6:0]  kr_rd_data = '0;
   logic        kr_rd_err = 1'b0;
   logic [6:0]  kr_wr_data;

   logic [6:0]  mem [16];
   logic        inj_err = 1'b0;
   int          wr_cnt = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 0;

   always #2.5 clk = ~clk;

   pgkey_rc_engine dut (
      .clk(clk), .rst_n(rst_n), .keys_on(keys_on),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm),
      .done(done), .perm_out(perm_out),
      .kr_rd_en(kr_rd_en), .kr_wr_en(kr_wr_en), .kr_addr(kr_addr),
      .kr_rd_data(kr_rd_data), .kr_rd_err(kr_rd_err), .kr_wr_data(kr_wr_data)
   );

   // Key RAM model: one cycle read latency, error flag registered with data.
   always @(posedge clk) begin
      if (kr_rd_en) begin
         kr_rd_data <= mem[kr_addr];
         kr_rd_err  <= inj_err;
      end
      if (kr_wr_en) begin
         mem[kr_addr] <= kr_wr_data;
         wr_cnt       <= wr_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input logic [15:0] addr, input logic [1:0] kind,
                          input logic [2:0] perm, input logic en,
                          input logic err, input logic [6:0] init);
      logic [3:0] page = addr[15:12];
      bit         st = (kind == 2'd1);
      logic [6:0] exp_key;
      logic [2:0] exp_perm;
      int         exp_w;
      int         w0;
      int         n;
      bit         saw_rd;
      exp_key  = (en && !err) ? (init | 7'h04 | (st ? 7'h02 : 7'h00)) : init;
      exp_w    = (exp_key != init) ? 1 : 0;
      exp_perm = (en && !err && !st && !init[1]) ? (perm & 3'b101) : perm;

      @(negedge clk);
      mem[page] = init;
      inj_err   = err;
      keys_on   = en;
      req_addr  = addr;
      req_kind  = kind;
      req_perm  = perm;
      req_valid = 1'b1;
      w0        = wr_cnt;
      chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      saw_rd = kr_rd_en;
      if (en) begin
         chk(kr_rd_en == 1'b1, "R3 read strobe after accept", int'(kr_rd_en), 1);
         chk(kr_addr == page, "R3 page index", int'(kr_addr), int'(page));
         chk(req_ready == 1'b0, "R9 busy", int'(req_ready), 0);
      end
      while (!done && n < 10) begin
         @(negedge clk);
         n++;
         if (kr_rd_en) saw_rd = 1'b1;
      end
      if (en) begin
         chk(n == 3, "R9 done latency", n, 3);
         if (err)
            chk(perm_out == exp_perm, "R8 flags on read error", int'(perm_out), int'(exp_perm));
         else
            chk(perm_out == exp_perm, "R6 adjusted flags", int'(perm_out), int'(exp_perm));
      end else begin
         chk(n == 1, "R2 bypass latency", n, 1);
         chk(perm_out == exp_perm, "R2 flags pass", int'(perm_out), int'(exp_perm));
         chk(!saw_rd, "R2 no key read", int'(saw_rd), 0);
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
      chk(req_ready == 1'b1, "R9 ready again", int'(req_ready), 1);
      if (st)
         chk(mem[page] == exp_key, "R4 R5 stored key (store)", int'(mem[page]), int'(exp_key));
      else
         chk(mem[page] == exp_key, "R4 R5 stored key (load/fetch)", int'(mem[page]), int'(exp_key));
      if (err)
         chk((wr_cnt - w0) == 0, "R8 no write on error", wr_cnt - w0, 0);
      else if (!en)
         chk((wr_cnt - w0) == 0, "R2 no write when off", wr_cnt - w0, 0);
      else
         chk((wr_cnt - w0) == exp_w, "R7 write count", wr_cnt - w0, exp_w);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(kr_rd_en == 1'b0 && kr_wr_en == 1'b0, "R1 RAM idle after reset",
          int'({kr_rd_en, kr_wr_en}), 0);

      // Every starting key under every access kind, enabled, no errors.
      for (int k = 0; k < 128; k++) begin
         for (int kd = 0; kd < 4; kd++) begin
            logic [15:0] a = {4'((k + kd) % 16), 12'((k * 97) % 4096)};
            logic [2:0]  p = (k % 2 == 0) ? 3'b111 : 3'(k % 8);
            run_vec(a, 2'(kd), p, 1'b1, 1'b0, 7'(k));
         end
      end
      // Disabled key handling.
      for (int k = 0; k < 32; k++)
         run_vec({4'(k % 16), 12'(k * 131)}, 2'(k % 4), 3'(k % 8), 1'b0, 1'b0, 7'(k * 5));
      // Read errors.
      for (int k = 0; k < 32; k++)
         run_vec({4'(15 - k % 16), 12'(k)}, 2'(k % 4), 3'b111 ^ 3'(k % 3), 1'b1, 1'b1, 7'(k * 3));
      // Extreme pages.
      run_vec(16'h0000, 2'd1, 3'b011, 1'b1, 1'b0, 7'h78);
      run_vec(16'hFFFF, 2'd2, 3'b111, 1'b1, 1'b0, 7'h7F);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule